// File: doc/BRIEF.md
# Two-Half Configurable Logic Cell

This block is one logic cell of a programmable fabric. It is split into two identical halves. Each half evaluates a 4-input lookup table, two 3-input lookup tables that form the operands of a one-bit full adder, and one output register. The adder bits of the two halves form a ripple chain: the carry out of the lower half feeds the upper half, and the carry out of the upper half leaves the cell for the next cell. The registers form a second chain. The lower register can take the cell's chain input and the upper register can take the lower register's value, so a column of cells can act as a shift path.

A controller loads the table contents and per-half mode bits through a parallel write port that runs on its own configuration clock. Each half chooses its register clock from three clock lines and its asynchronous clear from two clear lines. It also chooses which result appears on each of its two output drivers. One driver carries the lookup-table value or the adder sum. The other driver carries the register value at the same time, or the lookup-table value when the register is bypassed.

Top module: `lcell_top`

## Requirements
- R1: `lut_out[h]` equals bit `{d3,d2,d1,d0}` of half h's 16-bit table, where half h uses `data_in[4h+3:4h]` (d0 is the lowest bit).
- R2: Operands a and b of half h are bits `{d2,d1,d0}` of its first and second 8-bit tables. `sum_out[h]` is a^b^cin and the half's carry is majority(a,b,cin). Half 0 takes `carry_in`, half 1 takes half 0's carry, and `carry_out` is half 1's carry.
- R3: Register priority: a selected asynchronous clear forces 0 at once. On a selected clock edge with `ce` high, `sclr` loads 0, otherwise `sload` loads d3 of that half, otherwise the mode-selected data is loaded. With `ce` low the register holds.
- R4: Mode field `dsrc` (mode bits 1:0) picks the register data: 0 the table output, 1 the adder sum, 2 the chain value, and 3 the table output. Half 0's chain value is `chain_in`, half 1's chain value is register 0, and `chain_out` is register 1.
- R5: `route_a[h]` shows the sum when mode bit 2 is 1 and the table output when it is 0. `route_b[h]` shows the table output when mode bit 3 is 1 and the register otherwise.
- R6: Mode bits 5:4 pick the register clock from `clk_lines`: values 0, 1 and 2 pick that line and value 3 picks line 0. Edges on lines that are not picked leave the register unchanged.
- R7: Mode bit 6 picks the clear from `aclr_lines[0]` or `aclr_lines[1]` (active high). The line that is not picked has no effect.
- R8: A write with `cfg_we` high stores `cfg_wdata` on the next `clk` rising edge. `cfg_addr[3]` selects the half and `cfg_addr[2:0]` selects the word: 0 is table bits 7:0, 1 is table bits 15:8, 2 is the first small table, 3 is the second small table, and 4 is the mode byte. Words 5 to 7 are ignored, and no write changes a register value.
- R9: While `rst_n` is low, all configuration is zero: every table is 0, `dsrc` is 0, clock line 0 and clear line 0 are picked, and there is no bypass and no sum routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset of the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Half select (bit 3) and word select (bits 2:0) |
| cfg_wdata | input | 8 | Configuration write data |
| data_in | input | 8 | Data inputs, four per half |
| carry_in | input | 1 | Carry into half 0 |
| chain_in | input | 1 | Register chain input to half 0 |
| clk_lines | input | 3 | Candidate register clocks |
| aclr_lines | input | 2 | Candidate asynchronous clears, active high |
| ce | input | 1 | Register clock enable |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load of d3 |
| lut_out | output | 2 | 4-input table result per half |
| sum_out | output | 2 | Adder sum per half |
| route_a | output | 2 | Table-or-sum driver per half |
| route_b | output | 2 | Register-or-bypass driver per half |
| reg_out | output | 2 | Register value per half |
| carry_out | output | 1 | Carry out of half 1 |
| chain_out | output | 1 | Register chain output (register 1) |

## Verification
Random table contents and random modes, fed with random data and carries, compare the tables, the adder and the ripple link against a bench model. This separates a wrong table index, a wrong operand source and a wrong carry path. Random `ce`, `sclr`, `sload` and clears, often asserted together, expose a wrong control priority, and random `dsrc` values including 3 expose a swapped register source or a broken chain link. Directed pulses on the non-default clock lines and on single clear lines tell a correct line selection from a cell that follows line 0 or every line. Writes to unused words and to the other half, made while registers hold values, expose decode errors and writes that disturb state.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

   localparam int NUM_CLK_LINES = 3;
   localparam int NUM_CLR_LINES = 2;
   localparam int CLK_SEL_W     = $clog2(NUM_CLK_LINES);
   localparam int CLR_SEL_W     = $clog2(NUM_CLR_LINES);

   // register data source
   typedef enum logic [1:0] {
      DSRC_LUT   = 2'd0,
      DSRC_SUM   = 2'd1,
      DSRC_CHAIN = 2'd2,
      DSRC_ALT   = 2'd3
   } dsrc_e;

   // per-half mode byte, bit 0 at the right
   typedef struct packed {
      logic [CLR_SEL_W-1:0] aclr_sel;
      logic [CLK_SEL_W-1:0] clk_sel;
      logic                 bypass;
      logic                 route_sum;
      dsrc_e                dsrc;
   } half_mode_t;

   localparam int MODE_W = $bits(half_mode_t);

   // configuration word indices within a half
   localparam int W_L4_LO = 0;
   localparam int W_L4_HI = 1;
   localparam int W_LA    = 2;
   localparam int W_LB    = 3;
   localparam int W_MODE  = 4;

endpackage

// File: rtl/lcell_lut.sv
module lcell_lut #(
   parameter  int K = 4,
   localparam int W = 1 << K
) (
   input  logic [W-1:0] mask,
   input  logic [K-1:0] sel,
   output logic         y
);

   if (K < 1 || K > 6) begin : g_bad_k
      $error("lcell_lut: K out of range");
   end

   assign y = mask[sel];

endmodule

// File: rtl/lcell_cfg.sv
module lcell_cfg
   import lcell_pkg::*;
#(
   parameter  int AW  = 4,
   parameter  int DW  = 8,
   parameter  int NH  = 2,
   parameter  int L4W = 16,
   parameter  int L3W = 8,
   localparam int HB  = (NH > 1) ? $clog2(NH) : 1,
   localparam int WB  = AW - HB
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [AW-1:0]            addr,
   input  logic [DW-1:0]            wdata,
   output logic [NH-1:0][L4W-1:0]   l4_mask,
   output logic [NH-1:0][L3W-1:0]   la_mask,
   output logic [NH-1:0][L3W-1:0]   lb_mask,
   output half_mode_t [NH-1:0]      mode
);

   if (L4W != 2 * DW) begin : g_bad_l4
      $error("lcell_cfg: large table must span two data words");
   end
   if (L3W != DW) begin : g_bad_l3
      $error("lcell_cfg: small table must span one data word");
   end
   if (DW < MODE_W) begin : g_bad_mode
      $error("lcell_cfg: data word narrower than mode field");
   end
   if (WB < 3) begin : g_bad_aw
      $error("lcell_cfg: address too narrow for word map");
   end

   logic [HB-1:0] half_sel;
   logic [WB-1:0] word_sel;

   assign half_sel = addr[AW-1 -: HB];
   assign word_sel = addr[WB-1:0];

   for (genvar h = 0; h < NH; h++) begin : g_half
      logic hit;
      assign hit = we && (half_sel == HB'(h));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            l4_mask[h] <= '0;
            la_mask[h] <= '0;
            lb_mask[h] <= '0;
            mode[h]    <= '0;
         end else if (hit) begin
            case (word_sel)
               WB'(W_L4_LO): l4_mask[h][0 +: DW]  <= wdata;
               WB'(W_L4_HI): l4_mask[h][DW +: DW] <= wdata;
               WB'(W_LA):    la_mask[h]           <= wdata[L3W-1:0];
               WB'(W_LB):    lb_mask[h]           <= wdata[L3W-1:0];
               WB'(W_MODE):  mode[h]              <= half_mode_t'(wdata[MODE_W-1:0]);
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/lcell_half.sv
module lcell_half
   import lcell_pkg::*;
#(
   parameter  int KB        = 4,
   parameter  int KS        = 3,
   parameter  bit ACLR_LOW  = 1'b0,
   localparam int L4W       = 1 << KB,
   localparam int L3W       = 1 << KS
) (
   input  logic [NUM_CLK_LINES-1:0] clk_lines,
   input  logic [NUM_CLR_LINES-1:0] aclr_lines,
   input  logic [KB-1:0]            din,
   input  logic                     cin,
   input  logic                     chain_d,
   input  logic                     ce,
   input  logic                     sclr,
   input  logic                     sload,
   input  logic [L4W-1:0]           l4_mask,
   input  logic [L3W-1:0]           la_mask,
   input  logic [L3W-1:0]           lb_mask,
   input  half_mode_t               mode,
   output logic                     lut_y,
   output logic                     sum_y,
   output logic                     cout,
   output logic                     op_a,
   output logic                     op_b,
   output logic                     q,
   output logic                     route_a,
   output logic                     route_b
);

   if (KS >= KB) begin : g_bad_ks
      $error("lcell_half: small table must have fewer inputs");
   end

   logic rclk;
   logic aclr_raw;
   logic aclr_act;
   logic d_next;

   lcell_lut #(.K(KB)) u_lut_big (
      .mask (l4_mask),
      .sel  (din),
      .y    (lut_y)
   );

   lcell_lut #(.K(KS)) u_lut_a (
      .mask (la_mask),
      .sel  (din[KS-1:0]),
      .y    (op_a)
   );

   lcell_lut #(.K(KS)) u_lut_b (
      .mask (lb_mask),
      .sel  (din[KS-1:0]),
      .y    (op_b)
   );

   // one full-adder bit
   assign sum_y = op_a ^ op_b ^ cin;
   assign cout  = (op_a & op_b) | (cin & (op_a ^ op_b));

   // clock line pick; codes beyond the last line fall back to line 0
   always_comb begin
      rclk = clk_lines[0];
      if (int'(mode.clk_sel) < NUM_CLK_LINES) rclk = clk_lines[mode.clk_sel];
   end

   assign aclr_raw = aclr_lines[mode.aclr_sel];

   if (ACLR_LOW) begin : g_clr_low
      assign aclr_act = ~aclr_raw;
   end else begin : g_clr_high
      assign aclr_act = aclr_raw;
   end

   always_comb begin
      case (mode.dsrc)
         DSRC_SUM:   d_next = sum_y;
         DSRC_CHAIN: d_next = chain_d;
         default:    d_next = lut_y;
      endcase
   end

   always_ff @(posedge rclk or posedge aclr_act) begin
      if (aclr_act) begin
         q <= 1'b0;
      end else if (ce) begin
         if (sclr)       q <= 1'b0;
         else if (sload) q <= din[KB-1];
         else            q <= d_next;
      end
   end

   assign route_a = mode.route_sum ? sum_y : lut_y;
   assign route_b = mode.bypass    ? lut_y : q;

endmodule

// File: rtl/lcell_top.sv
module lcell_top
   import lcell_pkg::*;
#(
   parameter  int CFG_AW          = 4,
   parameter  int CFG_DW          = 8,
   parameter  int LUT_BIG         = 4,
   parameter  int LUT_SMALL       = 3,
   parameter  bit ACLR_ACTIVE_LOW = 1'b0,
   localparam int NHALF           = 2,
   localparam int DIN_W           = NHALF * LUT_BIG,
   localparam int L4W             = 1 << LUT_BIG,
   localparam int L3W             = 1 << LUT_SMALL,
   localparam int CFG_BITS        = NHALF * (L4W + 2 * L3W + MODE_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [CFG_AW-1:0]        cfg_addr,
   input  logic [CFG_DW-1:0]        cfg_wdata,
   input  logic [DIN_W-1:0]         data_in,
   input  logic                     carry_in,
   input  logic                     chain_in,
   input  logic [NUM_CLK_LINES-1:0] clk_lines,
   input  logic [NUM_CLR_LINES-1:0] aclr_lines,
   input  logic                     ce,
   input  logic                     sclr,
   input  logic                     sload,
   output logic [NHALF-1:0]         lut_out,
   output logic [NHALF-1:0]         sum_out,
   output logic [NHALF-1:0]         route_a,
   output logic [NHALF-1:0]         route_b,
   output logic [NHALF-1:0]         reg_out,
   output logic                     carry_out,
   output logic                     chain_out
);

   logic [NHALF-1:0][L4W-1:0] l4_mask;
   logic [NHALF-1:0][L3W-1:0] la_mask;
   logic [NHALF-1:0][L3W-1:0] lb_mask;
   half_mode_t [NHALF-1:0]    mode;
   logic [NHALF:0]            cy;
   logic [NHALF:0]            ch;
   logic [NHALF-1:0]          op_a;
   logic [NHALF-1:0]          op_b;
   logic [CFG_BITS-1:0]       cfg_flat;

   lcell_cfg #(
      .AW  (CFG_AW),
      .DW  (CFG_DW),
      .NH  (NHALF),
      .L4W (L4W),
      .L3W (L3W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .l4_mask (l4_mask),
      .la_mask (la_mask),
      .lb_mask (lb_mask),
      .mode    (mode)
   );

   assign cfg_flat = {l4_mask, la_mask, lb_mask, mode};

   assign cy[0]     = carry_in;
   assign ch[0]     = chain_in;
   assign carry_out = cy[NHALF];
   assign chain_out = ch[NHALF];

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      lcell_half #(
         .KB       (LUT_BIG),
         .KS       (LUT_SMALL),
         .ACLR_LOW (ACLR_ACTIVE_LOW)
      ) u_half (
         .clk_lines  (clk_lines),
         .aclr_lines (aclr_lines),
         .din        (data_in[h*LUT_BIG +: LUT_BIG]),
         .cin        (cy[h]),
         .chain_d    (ch[h]),
         .ce         (ce),
         .sclr       (sclr),
         .sload      (sload),
         .l4_mask    (l4_mask[h]),
         .la_mask    (la_mask[h]),
         .lb_mask    (lb_mask[h]),
         .mode       (mode[h]),
         .lut_y      (lut_out[h]),
         .sum_y      (sum_out[h]),
         .cout       (cy[h+1]),
         .op_a       (op_a[h]),
         .op_b       (op_b[h]),
         .q          (reg_out[h]),
         .route_a    (route_a[h]),
         .route_b    (route_b[h])
      );
      assign ch[h+1] = reg_out[h];
   end

endmodule

// File: rtl/lcell_checker.sv
module lcell_checker
   import lcell_pkg::*;
#(
   parameter  int NH  = 2,
   parameter  int L4W = 16,
   parameter  int L3W = 8,
   localparam int CW  = NH * (L4W + 2 * L3W + MODE_W)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_we,
   input logic [NUM_CLR_LINES-1:0] aclr_lines,
   input logic [NH-1:0]            reg_out,
   input logic [NH-1:0]            lut_out,
   input logic [NH-1:0]            sum_out,
   input logic [NH-1:0]            route_a,
   input logic [NH-1:0]            op_a,
   input logic [NH-1:0]            op_b,
   input logic                     carry_out,
   input logic [CW-1:0]            cfg_state
);

   // R7: with every clear line high, every register reads zero
   a_r7_all_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (&aclr_lines) |-> (reg_out == '0));

   // R5: the first driver only ever carries the table or the sum of its half
   a_r5_route_a_source: assert property (@(posedge clk) disable iff (!rst_n)
      (((route_a ^ lut_out) & (route_a ^ sum_out)) == '0));

   // R2: equal operands in the top half decide the outgoing carry
   a_r2_carry_majority: assert property (@(posedge clk) disable iff (!rst_n)
      (op_a[NH-1] == op_b[NH-1]) |-> (carry_out == op_a[NH-1]));

   // R2: equal operands in half 0 fix the carry passed into half 1
   a_r2_carry_link: assert property (@(posedge clk) disable iff (!rst_n)
      (op_a[0] == op_b[0]) |-> (sum_out[1] == (op_a[1] ^ op_b[1] ^ op_a[0])));

   // R8: configuration changes only after a write strobe
   a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_state));

endmodule

bind lcell_top lcell_checker u_lcell_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .aclr_lines (aclr_lines),
   .reg_out    (reg_out),
   .lut_out    (lut_out),
   .sum_out    (sum_out),
   .route_a    (route_a),
   .op_a       (op_a),
   .op_b       (op_b),
   .carry_out  (carry_out),
   .cfg_state  (cfg_flat)
);

// File: tb/lcell_top_bench.sv
module lcell_top_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] data_in = '0;
   logic       carry_in = 1'b0;
   logic       chain_in = 1'b0;
   logic       cl1 = 1'b0;
   logic       cl2 = 1'b0;
   logic [1:0] aclr_lines = '0;
   logic       ce = 1'b0;
   logic       sclr = 1'b0;
   logic       sload = 1'b0;
   logic [2:0] clk_lines;
   logic [1:0] lut_out, sum_out, route_a, route_b, reg_out;
   logic       carry_out, chain_out;

   assign clk_lines = {cl2, cl1, clk};

   always #(CLK_PERIOD/2) clk = ~clk;

   lcell_top u_lcell_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .data_in    (data_in),
      .carry_in   (carry_in),
      .chain_in   (chain_in),
      .clk_lines  (clk_lines),
      .aclr_lines (aclr_lines),
      .ce         (ce),
      .sclr       (sclr),
      .sload      (sload),
      .lut_out    (lut_out),
      .sum_out    (sum_out),
      .route_a    (route_a),
      .route_b    (route_b),
      .reg_out    (reg_out),
      .carry_out  (carry_out),
      .chain_out  (chain_out)
   );

   // bench model
   logic [15:0] m_l4 [2];
   logic [7:0]  m_la [2];
   logic [7:0]  m_lb [2];
   logic [7:0]  m_md [2];
   logic        mr   [2];
   logic        nx   [2];
   logic [1:0]  e_lut, e_sum, e_ra, e_rb;
   logic        e_cout;
   int          n_checks = 0;
   int          n_err = 0;

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int eff_sel(int h);
      int s = int'(m_md[h][5:4]);
      return (s == 3) ? 0 : s;
   endfunction

   // applies clears, then computes outputs and next register values
   task automatic model_eval();
      logic c = carry_in;
      for (int h = 0; h < 2; h++) begin
         logic [3:0] d = data_in[4*h +: 4];
         logic l, a, b, s, co, clr, src;
         l   = m_l4[h][d];
         a   = m_la[h][d[2:0]];
         b   = m_lb[h][d[2:0]];
         s   = a ^ b ^ c;
         co  = (a & b) | (a & c) | (b & c);
         clr = aclr_lines[m_md[h][6]];
         if (clr) mr[h] = 1'b0;
         e_lut[h] = l;
         e_sum[h] = s;
         e_ra[h]  = m_md[h][2] ? s : l;
         e_rb[h]  = m_md[h][3] ? l : mr[h];
         case (m_md[h][1:0])
            2'd1:    src = s;
            2'd2:    src = (h == 0) ? chain_in : mr[0];
            default: src = l;
         endcase
         if (clr)        nx[h] = 1'b0;
         else if (!ce)   nx[h] = mr[h];
         else if (sclr)  nx[h] = 1'b0;
         else if (sload) nx[h] = d[3];
         else            nx[h] = src;
         c = co;
      end
      e_cout = c;
   endtask

   task automatic check_all(input string reg_req);
      model_eval();
      chk("R1", "lut_out", {6'd0, lut_out}, {6'd0, e_lut});
      chk("R2", "sum_out", {6'd0, sum_out}, {6'd0, e_sum});
      chk("R2", "carry_out", {7'd0, carry_out}, {7'd0, e_cout});
      chk("R5", "route_a", {6'd0, route_a}, {6'd0, e_ra});
      chk("R5", "route_b", {6'd0, route_b}, {6'd0, e_rb});
      chk(reg_req, "reg_out", {6'd0, reg_out}, {6'd0, mr[1], mr[0]});
      chk("R4", "chain_out", {7'd0, chain_out}, {7'd0, mr[1]});
   endtask

   // entered just after a falling edge of clk, inputs already driven
   task automatic run_cycle(input string req);
      #1;
      check_all("R3");
      @(posedge clk);
      @(negedge clk);
      for (int h = 0; h < 2; h++) if (eff_sel(h) == 0) mr[h] = nx[h];
      chk(req, "reg_out after edge", {6'd0, reg_out}, {6'd0, mr[1], mr[0]});
   endtask

   // pulses clock line k while clk is low
   task automatic pulse_line(input int k);
      #1;
      model_eval();
      if (k == 1) cl1 = 1'b1; else cl2 = 1'b1;
      #1;
      cl1 = 1'b0;
      cl2 = 1'b0;
      #1;
      for (int h = 0; h < 2; h++) if (eff_sel(h) == k) mr[h] = nx[h];
      chk("R6", "reg_out after line pulse", {6'd0, reg_out}, {6'd0, mr[1], mr[0]});
   endtask

   // entered just after a falling edge; returns at the next falling edge
   task automatic cfg_wr(input logic [3:0] a, input logic [7:0] d);
      int h = int'(a[3]);
      cfg_we    = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      case (a[2:0])
         3'd0: m_l4[h][7:0]  = d;
         3'd1: m_l4[h][15:8] = d;
         3'd2: m_la[h]       = d;
         3'd3: m_lb[h]       = d;
         3'd4: m_md[h]       = {1'b0, d[6:0]};
         default: ;
      endcase
   endtask

   task automatic program_half(input int h, input logic [15:0] l4,
                               input logic [7:0] la, input logic [7:0] lb,
                               input logic [7:0] md);
      logic [3:0] base = {h[0], 3'b000};
      cfg_wr(base | 4'd0, l4[7:0]);
      cfg_wr(base | 4'd1, l4[15:8]);
      cfg_wr(base | 4'd2, la);
      cfg_wr(base | 4'd3, lb);
      cfg_wr(base | 4'd4, md);
   endtask

   task automatic drive_random();
      data_in    = 8'($urandom);
      carry_in   = 1'($urandom);
      chain_in   = 1'($urandom);
      ce         = ($urandom % 4) != 0;
      sclr       = ($urandom % 10) == 0;
      sload      = ($urandom % 7) == 0;
      aclr_lines = {($urandom % 20) == 0, ($urandom % 20) == 0};
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_4c11));
      for (int h = 0; h < 2; h++) begin
         m_l4[h] = '0; m_la[h] = '0; m_lb[h] = '0; m_md[h] = '0; mr[h] = 1'b0;
      end

      // R9: reset configuration
      aclr_lines = 2'b11;
      rst_n      = 1'b0;
      repeat (3) @(negedge clk);
      data_in  = 8'hA7;
      carry_in = 1'b1;
      #1;
      chk("R9", "lut_out in reset", {6'd0, lut_out}, 8'h00);
      chk("R9", "sum_out in reset", {6'd0, sum_out}, 8'h01);
      chk("R9", "route_a in reset", {6'd0, route_a}, 8'h00);
      chk("R9", "reg_out in reset", {6'd0, reg_out}, 8'h00);
      @(negedge clk);
      rst_n      = 1'b1;
      aclr_lines = 2'b00;
      carry_in   = 1'b0;
      @(negedge clk);

      // R6 / R7: directed clock line and clear line selection
      program_half(0, 16'hFFFF, 8'h00, 8'h00, 8'h10);
      program_half(1, 16'hFFFF, 8'h00, 8'h00, 8'h60);
      ce = 1'b1;
      for (int i = 0; i < 3; i++) run_cycle("R6");
      chk("R6", "line 0 ignored", {6'd0, reg_out}, 8'h00);
      pulse_line(1);
      chk("R6", "line 1 loads half 0", {6'd0, reg_out}, 8'h01);
      pulse_line(2);
      chk("R6", "line 2 loads half 1", {6'd0, reg_out}, 8'h03);
      aclr_lines = 2'b01;
      #1;
      check_all("R7");
      chk("R7", "clear line 0 only", {6'd0, reg_out}, 8'h02);
      aclr_lines = 2'b00;
      @(negedge clk);
      pulse_line(1);
      aclr_lines = 2'b10;
      #1;
      check_all("R7");
      chk("R7", "clear line 1 only", {6'd0, reg_out}, 8'h01);
      aclr_lines = 2'b00;
      @(negedge clk);
      pulse_line(2);
      ce = 1'b0;

      // R8: unused words and the other half leave state alone
      cfg_wr(4'd5, 8'hFF);
      cfg_wr(4'd6, 8'hFF);
      cfg_wr(4'd7, 8'hFF);
      cfg_wr(4'd13, 8'h00);
      cfg_wr(4'd15, 8'h00);
      cfg_wr(4'd10, 8'h5A);
      check_all("R8");
      chk("R8", "registers kept over writes", {6'd0, reg_out}, 8'h03);

      // random configurations and stimulus
      for (int t = 0; t < 10; t++) begin
         ce = 1'b0; sclr = 1'b0; sload = 1'b0; aclr_lines = 2'b00;
         for (int h = 0; h < 2; h++) begin
            logic [7:0] md;
            md = 8'($urandom) & 8'h4F;
            if ($urandom % 2) md[5:4] = 2'b11;
            program_half(h, 16'($urandom), 8'($urandom), 8'($urandom), md);
         end
         check_all("R8");
         for (int i = 0; i < 250; i++) begin
            drive_random();
            run_cycle("R3/R4");
         end
      end

      finish_run();
   end

endmodule